// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple word-wide host port and one single-data-rate SDRAM device. The device has four banks of 4096 rows by 512 columns of 16-bit words. After reset the controller runs the device's power-up sequence and programs the mode register. From then on it turns each accepted host request into a closed-page access: it opens the row, issues one column command, and then closes the bank again. Between requests it inserts the periodic auto-refresh commands that the device needs to keep its contents.

The host presents a request with a read/write flag, a 23-bit word address and write data. The request is taken on a clock edge where both `req_valid` and `req_ready` are high. Read data comes back on `rd_data` with a one-cycle `rd_valid` strobe. Every device timing gap is a parameter counted in clock cycles. The defaults are a 2-2-2 speed grade with two-cycle write recovery, and a refresh spacing of 2000 cycles, which keeps 4096 refreshes inside 64 ms at 133 MHz with margin. The controller drives the data bus through a separate output, output-enable and input, so a pad ring can build the tristate.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: From reset, the controller holds NOP on the command pins with `sd_dqm` all ones and `req_ready` low. The first other command appears exactly T_POWERUP cycles after reset is released.
- R2: Initialization issues, in this order: PRECHARGE with A10 high (all banks), AUTO REFRESH T_RP cycles later, a second AUTO REFRESH T_RFC cycles after the first, and LOAD MODE T_RFC cycles after the second. LOAD MODE carries BA=0 and A=0x020 (burst length 1, sequential, CAS latency 2 in A[6:4]). No request is accepted before T_MRD cycles have passed after LOAD MODE.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n}: NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000. No other code is driven.
- R4: `req_addr` is split as bank=[22:21], row=[20:9] and column=[8:0]. ACTIVE carries the bank on BA and the row on A. READ and WRITE carry the same bank, the column on A[8:0], and A10 low.
- R5: A READ or WRITE follows its ACTIVE by exactly T_RCD cycles.
- R6: In a WRITE cycle, and only then, `sd_dq_oe` is high, `sd_dq_out` holds the request's write data and `sd_dqm` is zero. The closing PRECHARGE comes exactly T_WR cycles after the WRITE.
- R7: `rd_valid` is high for exactly one cycle, CAS_LAT cycles after each READ, and in that cycle `rd_data` equals `sd_dq_in`. The closing PRECHARGE comes CAS_LAT cycles after the READ.
- R8: Each access ends with a PRECHARGE to its own bank, with A10 low. No ACTIVE or AUTO REFRESH comes earlier than T_RP cycles after a PRECHARGE.
- R9: `req_ready` is low while a row is open. Each accepted request produces exactly one ACTIVE and one column command, in the order the requests were accepted.
- R10: No command other than NOP is issued within T_RFC cycles after an AUTO REFRESH.
- R11: After initialization, AUTO REFRESH is issued only while all banks are closed. Two refreshes are never more than REF_INTERVAL plus one access sequence apart.
- R12: A refresh that has fallen due is served ahead of a waiting host request. The refresh bound therefore holds under back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column / mode address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Data to device |
| sd_dq_oe | output | 1 | Drive enable for the data bus |
| sd_dq_in | input | 16 | Data from device |

## Verification
An accepted request shows up as ACTIVE in the cycle after the accepting edge. The column command follows exactly T_RCD cycles later. PRECHARGE follows T_WR cycles after a WRITE or CAS_LAT cycles after a READ, and `rd_valid` rises CAS_LAT cycles after the READ. The bench decodes the command pins at every falling edge. For each observed command it measures the distance in cycles to the command it must follow and compares that to the exact figure. A behavioural device model drives `sd_dq_in` only during the cycle a READ's data is due, so a strobe one cycle early or late is caught.

// File: rtl/sdr_cmd_ctrl.sv
module sdr_cmd_ctrl #(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int T_POWERUP    = 13300,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int CAS_LAT      = 2,
  parameter int T_WR         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int REF_INTERVAL = 2000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rd_valid,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_a,
  output logic [DATA_W/8-1:0]             sd_dqm,
  output logic [DATA_W-1:0]               sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DATA_W-1:0]               sd_dq_in
);

  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int CW = $clog2(T_POWERUP + T_RFC + T_RP + T_WR + CAS_LAT + T_RCD + T_MRD + 1);
  localparam int RW = $clog2(REF_INTERVAL + 1);

  localparam logic [CW-1:0] PWR_LD = CW'(T_POWERUP - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] WR_LD  = CW'(T_WR - 1);
  localparam logic [CW-1:0] CL_LD  = CW'(CAS_LAT - 1);
  localparam logic [CW-1:0] RFC_LD = CW'(T_RFC - 1);
  localparam logic [CW-1:0] MRD_LD = CW'(T_MRD - 1);
  localparam logic [RW-1:0] REF_LD = RW'(REF_INTERVAL - 1);

  localparam logic [ROW_W-1:0] A_ALLBANK = ROW_W'(1024);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [2:0] {
    S_PWR, S_REF1, S_REF2, S_MRS, S_IDLE, S_ACCESS, S_CLOSE
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [3:0]        cmd_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  a_q;
  logic [DATA_W-1:0] dq_q;
  logic              oe_q;
  logic [CAS_LAT:0]  rd_pipe;
  logic [RW-1:0]     ref_cnt;
  logic              ref_pend;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  wire init_done = (st == S_IDLE) || (st == S_ACCESS) || (st == S_CLOSE);
  wire slot      = (cnt == '0);
  wire take_ref  = (st == S_IDLE) && slot && ref_pend;
  wire issue_rd  = (st == S_ACCESS) && slot && !we_q;

  assign req_ready = (st == S_IDLE) && slot && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign sd_dqm    = init_done ? '0 : '1;
  assign rd_valid  = rd_pipe[CAS_LAT];
  assign rd_data   = sd_dq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= REF_LD;
      ref_pend <= 1'b0;
    end else if (!init_done) begin
      ref_cnt  <= REF_LD;
      ref_pend <= 1'b0;
    end else if (ref_cnt == '0) begin
      ref_cnt  <= REF_LD;
      ref_pend <= 1'b1;
    end else begin
      ref_cnt <= ref_cnt - 1'b1;
      if (take_ref) ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_PWR;
      cnt     <= PWR_LD;
      cmd_q   <= C_NOP;
      ba_q    <= '0;
      a_q     <= '0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
      rd_pipe <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      cmd_q   <= C_NOP;
      oe_q    <= 1'b0;
      rd_pipe <= {rd_pipe[CAS_LAT-1:0], issue_rd};
      if (!slot) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_PWR: begin
            cmd_q <= C_PRE;
            a_q   <= A_ALLBANK;
            cnt   <= RP_LD;
            st    <= S_REF1;
          end
          S_REF1: begin
            cmd_q <= C_REF;
            cnt   <= RFC_LD;
            st    <= S_REF2;
          end
          S_REF2: begin
            cmd_q <= C_REF;
            cnt   <= RFC_LD;
            st    <= S_MRS;
          end
          S_MRS: begin
            cmd_q <= C_LMR;
            ba_q  <= '0;
            a_q   <= MODE_WORD;
            cnt   <= MRD_LD;
            st    <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_pend) begin
              cmd_q <= C_REF;
              cnt   <= RFC_LD;
            end else if (req_valid) begin
              cmd_q   <= C_ACT;
              ba_q    <= req_addr[COL_W+ROW_W +: BANK_W];
              a_q     <= req_addr[COL_W +: ROW_W];
              we_q    <= req_write;
              addr_q  <= req_addr;
              wdata_q <= req_wdata;
              cnt     <= RCD_LD;
              st      <= S_ACCESS;
            end
          end
          S_ACCESS: begin
            a_q <= ROW_W'(addr_q[COL_W-1:0]);
            if (we_q) begin
              cmd_q <= C_WR;
              dq_q  <= wdata_q;
              oe_q  <= 1'b1;
              cnt   <= WR_LD;
            end else begin
              cmd_q <= C_RD;
              cnt   <= CL_LD;
            end
            st <= S_CLOSE;
          end
          S_CLOSE: begin
            cmd_q <= C_PRE;
            a_q   <= '0;
            cnt   <= RP_LD;
            st    <= S_IDLE;
          end
          default: st <= S_PWR;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdr_cmd_ctrl_chk.sv
module sdr_cmd_ctrl_chk #(
  parameter int DQM_W   = 2,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cmd,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             dq_oe,
  input logic [DQM_W-1:0] dqm
);

  wire is_nop = (cmd == 4'b0111);
  wire is_act = (cmd == 4'b0011);
  wire is_rd  = (cmd == 4'b0101);
  wire is_wr  = (cmd == 4'b0100);
  wire is_pre = (cmd == 4'b0010);
  wire is_ref = (cmd == 4'b0001);

  logic [7:0] since_act, since_pre, since_wr, since_ref;

  function automatic logic [7:0] bump(input logic hit, input logic [7:0] v);
    return hit ? 8'd1 : ((v == 8'hFF) ? v : v + 8'd1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      since_pre <= 8'hFF;
      since_wr  <= 8'hFF;
      since_ref <= 8'hFF;
    end else begin
      since_act <= bump(is_act, since_act);
      since_pre <= bump(is_pre, since_pre);
      since_wr  <= bump(is_wr, since_wr);
      since_ref <= bump(is_ref, since_ref);
    end
  end

  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (is_rd || is_wr) |-> since_act >= 8'(T_RCD)); // R5
  AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (is_act || is_ref) |-> since_pre >= 8'(T_RP)); // R8
  AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> since_wr >= 8'(T_WR)); // R6
  AST_RFC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !is_nop |-> since_ref >= 8'(T_RFC)); // R10
  AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n) is_rd |-> ##CAS_LAT rd_valid); // R7
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) is_wr |-> (dq_oe && dqm == '0)); // R6
  AST_OE_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> is_wr); // R6
  AST_BUSY_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n) is_act |=> !req_ready); // R9

endmodule

bind sdr_cmd_ctrl sdr_cmd_ctrl_chk #(
  .DQM_W(DATA_W/8), .T_RP(T_RP), .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_WR(T_WR), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .req_ready(req_ready), .rd_valid(rd_valid), .dq_oe(sd_dq_oe), .dqm(sd_dqm)
);

// File: tb/sdr_cmd_ctrl_test.sv
module sdr_cmd_ctrl_test;

  localparam int TPU = 40, TRP = 2, TRCD = 2, CL = 2, TWR = 2, TRFC = 7, TMRD = 2, REFI = 150;
  localparam int BOUND = REFI + TRCD + ((CL > TWR) ? CL : TWR) + TRP + TRFC + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [15:0] sd_dq_in = 16'hBAD0;
  logic [1:0] sd_ba, sd_dqm;
  logic [11:0] sd_a;

  always #2 clk = ~clk;

  sdr_cmd_ctrl #(.T_POWERUP(TPU), .T_RP(TRP), .T_RCD(TRCD), .CAS_LAT(CL), .T_WR(TWR),
                 .T_RFC(TRFC), .T_MRD(TMRD), .REF_INTERVAL(REFI)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  typedef struct packed { logic we; logic [22:0] addr; logic [15:0] d; } hreq_t;

  int n_run = 0, n_fail = 0;
  bit done = 0, sat = 0;
  hreq_t reqq[$];
  logic [15:0] rdexp_q[$];
  logic [15:0] hostmem[int];
  logic [15:0] devmem[int];

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input logic [22:0] k);
    return k[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [22:0] mk(input int b, input int r, input int c);
    return {2'(b), 12'(r), 9'(c)};
  endfunction

  // reference model of device and protocol, sampled mid-cycle
  int cyc = 0, phase = 0, rd_due = -1, n_ref = 0;
  int t_pre = -1000, t_act = -1000, t_wr = -1000, t_rd = -1000, t_ref = -1000, t_lmr = -1000, t_base = 0;
  bit open = 0;
  hreq_t cur;
  logic [15:0] rd_word = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
    end else begin
      logic [3:0] cmd;
      logic [15:0] exp;
      int key;
      cyc++;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      chk(rd_valid === (cyc == rd_due), "R7", rd_valid, cyc == rd_due);
      if (rd_valid === 1'b1 && cyc == rd_due) begin
        exp = (rdexp_q.size() > 0) ? rdexp_q.pop_front() : 16'hxxxx;
        chk(rd_data === exp, "R7", rd_data, exp);
      end
      chk(sd_dq_oe === (cmd == 4'b0100), "R6", sd_dq_oe, cmd == 4'b0100);
      if (phase < 4 || cyc < t_lmr + TMRD - 1 || open)
        chk(req_ready === 1'b0, (phase < 4) ? "R2" : "R9", req_ready, 0);
      if (cmd != 4'b0111 && phase >= 2)
        chk(cyc - t_ref >= TRFC, "R10", cyc - t_ref, TRFC);
      key = int'({sd_ba, sd_a[8:0]});
      case (cmd)
        4'b0111: if (phase == 0) chk(sd_dqm === 2'b11, "R1", sd_dqm, 3);
        4'b0010: begin
          if (phase == 0) begin
            chk(cyc == TPU, "R1", cyc, TPU);
            chk(sd_a[10] === 1'b1, "R2", sd_a[10], 1);
            phase = 1;
          end else begin
            chk(open && sd_a[10] === 1'b0 && sd_ba === cur.addr[22:21], "R8", sd_ba, cur.addr[22:21]);
            if (cur.we) chk(cyc - t_wr == TWR, "R6", cyc - t_wr, TWR);
            else        chk(cyc - t_rd == CL, "R7", cyc - t_rd, CL);
            open = 0;
          end
          t_pre = cyc;
        end
        4'b0001: begin
          if (phase == 1) begin
            chk(cyc - t_pre == TRP, "R2", cyc - t_pre, TRP);
            phase = 2;
          end else if (phase == 2) begin
            chk(cyc - t_ref == TRFC, "R2", cyc - t_ref, TRFC);
            phase = 3;
          end else begin
            chk(!open, "R11", open, 0);
            chk(cyc - t_pre >= TRP, "R8", cyc - t_pre, TRP);
            chk(cyc - t_base <= BOUND, sat ? "R12" : "R11", cyc - t_base, BOUND);
            t_base = cyc;
            n_ref++;
          end
          t_ref = cyc;
        end
        4'b0000: begin
          chk(phase == 3 && cyc - t_ref == TRFC, "R2", cyc - t_ref, TRFC);
          chk(sd_a === 12'h020 && sd_ba === 2'b00, "R2", {sd_ba, sd_a}, 12'h020);
          phase = 4;
          t_lmr = cyc;
          t_base = cyc;
        end
        4'b0011: begin
          chk(phase == 4 && !open, "R9", open, 0);
          chk(cyc - t_lmr >= TMRD, "R2", cyc - t_lmr, TMRD);
          chk(cyc - t_pre >= TRP, "R8", cyc - t_pre, TRP);
          if (reqq.size() == 0) begin
            chk(0, "R9", 1, 0);
            cur = '0;
          end else begin
            cur = reqq.pop_front();
            chk({sd_ba, sd_a} === cur.addr[22:9], "R4", {sd_ba, sd_a}, cur.addr[22:9]);
          end
          open = 1;
          t_act = cyc;
        end
        4'b0101, 4'b0100: begin
          chk(open, "R4", open, 1);
          chk(cyc - t_act == TRCD, "R5", cyc - t_act, TRCD);
          chk(sd_ba === cur.addr[22:21] && sd_a[8:0] === cur.addr[8:0] && sd_a[10] === 1'b0,
              "R4", {sd_ba, sd_a}, {cur.addr[22:21], 3'b000, cur.addr[8:0]});
          if (cmd == 4'b0100) begin
            chk(sd_dq_out === cur.d, "R6", sd_dq_out, cur.d);
            chk(sd_dqm === 2'b00, "R6", sd_dqm, 0);
            devmem[{cur.addr[22:21], cur.addr[20:9], cur.addr[8:0]}] = sd_dq_out;
            t_wr = cyc;
          end else begin
            key = int'(cur.addr);
            rd_word = devmem.exists(key) ? devmem[key] : dflt(cur.addr);
            rd_due = cyc + CL;
            t_rd = cyc;
          end
        end
        default: chk(0, "R3", cmd, 4'b0111);
      endcase
      sd_dq_in = (cyc + 1 == rd_due) ? rd_word : 16'hBAD0;
    end
  end

  task automatic host_req(input bit we, input logic [22:0] addr, input logic [15:0] d);
    req_write = we;
    req_addr  = addr;
    req_wdata = d;
    req_valid = 1'b1;
    while (req_ready !== 1'b1) @(negedge clk);
    reqq.push_back('{we, addr, d});
    if (we) hostmem[int'(addr)] = d;
    else rdexp_q.push_back(hostmem.exists(int'(addr)) ? hostmem[int'(addr)] : dflt(addr));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R9): got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b0, "R1", req_ready, 0);
    chk(rd_valid === 1'b0, "R1", rd_valid, 0);
    chk(sd_dq_oe === 1'b0, "R1", sd_dq_oe, 0);
    chk(sd_dqm === 2'b11, "R1", sd_dqm, 3);
    while (req_ready !== 1'b1) @(negedge clk);

    host_req(1, mk(0, 0, 0), 16'h1111);
    host_req(1, mk(3, 4095, 511), 16'hA5C3);
    host_req(1, mk(1, 100, 7), 16'h0001);
    host_req(1, mk(2, 2048, 256), 16'hFFFF);
    host_req(0, mk(3, 4095, 511), 0);
    host_req(0, mk(0, 0, 0), 0);
    repeat (3) @(negedge clk);
    host_req(0, mk(2, 2048, 256), 0);
    host_req(0, mk(1, 100, 7), 0);
    host_req(0, mk(2, 5, 5), 0);
    host_req(1, mk(1, 100, 7), 16'h7E57);
    host_req(0, mk(1, 100, 7), 0);

    sat = 1;
    for (int i = 0; i < 80; i++) begin
      logic [22:0] a;
      a = mk(i % 4, (i * 37) % 4096, (i * 11) % 512);
      if (i % 2 == 0) host_req(1, a, 16'(i * 16'h0101 + 3));
      else host_req(0, mk((i - 1) % 4, ((i - 1) * 37) % 4096, ((i - 1) * 11) % 512), 0);
    end
    sat = 0;

    repeat (400) @(negedge clk);
    host_req(0, mk(0, 0, 0), 0);
    repeat (20) @(negedge clk);
    chk(reqq.size() == 0, "R9", reqq.size(), 0);
    chk(rdexp_q.size() == 0, "R7", rdexp_q.size(), 0);
    chk(n_ref >= 5, "R11", n_ref, 5);
    done = 1;
    summary();
    $finish;
  end

endmodule